// File: doc/BRIEF.md
# Half-Word Shifter with Status Flags

This block shifts one 16-bit half of a 32-bit source word by an immediate distance of 0 to 15 places. It then places the 16-bit outcome into one half of a 32-bit destination word and leaves the other half of that word as it was. The shift can go left, go right with sign fill, or go right with zero fill. A fourth code passes the chosen half through without shifting it.

Along with the merged word, the block reports five status bits: zero, negative, carry and two overflow bits. Zero and negative are taken from the 16-bit shift outcome alone. Carry and both overflow bits stay cleared for these non-saturating immediate shifts.

The datapath is combinational from the operand inputs to a single output register stage. The merged word and the flags therefore appear one clock after the operands are presented. A synchronous active-high reset clears that register stage.

Top module: `hws_shifter`

## Requirements
- R1: `src_hi` = 0 selects bits 15:0 of `src_word` as the operand, and `src_hi` = 1 selects bits 31:16.
- R2: `dst_hi` = 0 writes the 16-bit outcome to bits 15:0 of `dst_new`, and `dst_hi` = 1 writes it to bits 31:16. All four source/destination half combinations work.
- R3: The half of `dst_new` that is not written equals the same half of `dst_old`.
- R4: With `op` = 2'b00 the operand shifts left, with zeros entering at bit 0 and bits above bit 15 dropped (0x0001 by 15 gives 0x8000).
- R5: With `op` = 2'b01 the operand shifts right and copies of bit 15 fill the vacated bits (0x8000 by 4 gives 0xF800).
- R6: With `op` = 2'b10 the operand shifts right and zeros fill the vacated bits (0x8000 by 4 gives 0x0800).
- R7: With `op` = 2'b11 the operand passes unchanged, whatever the value of `shamt`.
- R8: A `shamt` of 0 passes the operand unchanged for every shift code.
- R9: `flag_zero` is 1 exactly when the 16-bit outcome is 0x0000. The kept half of the destination has no effect on it.
- R10: `flag_neg` equals bit 15 of the 16-bit outcome.
- R11: `flag_carry`, `flag_ovf0` and `flag_ovf1` are always 0, including when a left shift moves a 1 into bit 15.
- R12: Outputs are registered, so they reflect the inputs sampled at the previous rising edge. A synchronous reset sets `dst_new` and all five flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_word | input | 32 | Source register value |
| dst_old | input | 32 | Present destination register value |
| src_hi | input | 1 | Operand half select (1 = bits 31:16) |
| dst_hi | input | 1 | Written half select (1 = bits 31:16) |
| op | input | 2 | 00 left, 01 right with sign fill, 10 right with zero fill, 11 pass |
| shamt | input | 4 | Shift distance 0..15 |
| dst_new | output | 32 | Merged destination value |
| flag_zero | output | 1 | 16-bit outcome is zero |
| flag_neg | output | 1 | Bit 15 of the 16-bit outcome |
| flag_carry | output | 1 | Carry, always 0 |
| flag_ovf0 | output | 1 | First overflow bit, always 0 |
| flag_ovf1 | output | 1 | Second overflow bit, always 0 |

## Verification
The merge of the outcome into one destination half and the flag computation happen in the same cycle. A fault could let the kept half leak into the flags, or let the outcome spill into the wrong half. To provoke this, the bench pairs destination words whose kept half is nonzero, or has bit 15 set, with operands whose outcome is zero or positive. It also pairs zero kept halves with nonzero outcomes. Each case is judged by comparing the zero and negative flags against the 16-bit outcome alone, and the kept half against `dst_old`, in the cycle after the operands are applied.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    OP_SHL  = 2'b00,
    OP_SHRA = 2'b01,
    OP_SHRL = 2'b10,
    OP_PASS = 2'b11
  } hws_op_e;

  typedef struct packed {
    logic zero;
    logic neg;
    logic carry;
    logic ovf0;
    logic ovf1;
  } hws_flags_t;
endpackage

// File: rtl/hws_half_select.sv
module hws_half_select #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] word_i,
  input  logic                hi_i,
  output logic [HALF_W-1:0]   half_o
);
  always_comb begin
    if (hi_i) half_o = word_i[2*HALF_W-1:HALF_W];
    else      half_o = word_i[HALF_W-1:0];
  end
endmodule

// File: rtl/hws_shift_core.sv
module hws_shift_core
  import hws_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int SHAMT_W = $clog2(HALF_W)
) (
  input  logic [HALF_W-1:0]  opnd_i,
  input  hws_op_e            op_i,
  input  logic [SHAMT_W-1:0] amt_i,
  output logic [HALF_W-1:0]  res_o
);
  localparam int STAGES = SHAMT_W;

  logic [STAGES:0][HALF_W-1:0] stg;
  logic [SHAMT_W-1:0] eff_amt;
  logic go_left;
  logic fill_bit;

  // A pass code shifts by nothing.
  assign eff_amt  = (op_i == OP_PASS) ? '0 : amt_i;
  assign go_left  = (op_i == OP_SHL);
  assign fill_bit = (op_i == OP_SHRA) ? opnd_i[HALF_W-1] : 1'b0;
  assign stg[0]   = opnd_i;

  // Logarithmic shifter: stage k moves by 2**k when amount bit k is set.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int DIST = 1 << k;
    logic [HALF_W-1:0] lft;
    logic [HALF_W-1:0] rgt;
    logic [HALF_W-1:0] fill_mask;
    assign fill_mask = ~({HALF_W{1'b1}} >> DIST);
    assign lft = stg[k] << DIST;
    assign rgt = (stg[k] >> DIST) | (fill_bit ? fill_mask : '0);
    assign stg[k+1] = eff_amt[k] ? (go_left ? lft : rgt) : stg[k];
  end

  assign res_o = stg[STAGES];
endmodule

// File: rtl/hws_merge_flags.sv
module hws_merge_flags
  import hws_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   res_i,
  input  logic [2*HALF_W-1:0] dst_old_i,
  input  logic                dst_hi_i,
  output logic [2*HALF_W-1:0] dst_new_o,
  output hws_flags_t          flags_o
);
  always_comb begin
    if (dst_hi_i) dst_new_o = {res_i, dst_old_i[HALF_W-1:0]};
    else          dst_new_o = {dst_old_i[2*HALF_W-1:HALF_W], res_i};
  end

  // Flags come from the shifted half alone.
  always_comb begin
    flags_o.zero  = (res_i == '0);
    flags_o.neg   = res_i[HALF_W-1];
    flags_o.carry = 1'b0;
    flags_o.ovf0  = 1'b0;
    flags_o.ovf1  = 1'b0;
  end
endmodule

// File: rtl/hws_shifter.sv
module hws_shifter
  import hws_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int SHAMT_W = $clog2(HALF_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*HALF_W-1:0] src_word,
  input  logic [2*HALF_W-1:0] dst_old,
  input  logic                src_hi,
  input  logic                dst_hi,
  input  logic [1:0]          op,
  input  logic [SHAMT_W-1:0]  shamt,
  output logic [2*HALF_W-1:0] dst_new,
  output logic                flag_zero,
  output logic                flag_neg,
  output logic                flag_carry,
  output logic                flag_ovf0,
  output logic                flag_ovf1
);
  localparam int WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] opnd;
  logic [HALF_W-1:0] shres;
  logic [WORD_W-1:0] merged;
  hws_flags_t        flg;

  hws_half_select #(.HALF_W(HALF_W)) u_sel (
    .word_i (src_word),
    .hi_i   (src_hi),
    .half_o (opnd)
  );

  hws_shift_core #(.HALF_W(HALF_W), .SHAMT_W(SHAMT_W)) u_core (
    .opnd_i (opnd),
    .op_i   (hws_op_e'(op)),
    .amt_i  (shamt),
    .res_o  (shres)
  );

  hws_merge_flags #(.HALF_W(HALF_W)) u_merge (
    .res_i     (shres),
    .dst_old_i (dst_old),
    .dst_hi_i  (dst_hi),
    .dst_new_o (merged),
    .flags_o   (flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_new    <= '0;
      flag_zero  <= 1'b0;
      flag_neg   <= 1'b0;
      flag_carry <= 1'b0;
      flag_ovf0  <= 1'b0;
      flag_ovf1  <= 1'b0;
    end else begin
      dst_new    <= merged;
      flag_zero  <= flg.zero;
      flag_neg   <= flg.neg;
      flag_carry <= flg.carry;
      flag_ovf0  <= flg.ovf0;
      flag_ovf1  <= flg.ovf1;
    end
  end

  // Check-only state: one cycle of history after reset, and the written half.
  logic              seen_q;
  logic              wr_hi_q;
  logic [HALF_W-1:0] wr_half;
  logic [HALF_W-1:0] kept_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      wr_hi_q <= 1'b0;
    end else begin
      seen_q  <= 1'b1;
      wr_hi_q <= dst_hi;
    end
  end

  assign wr_half   = wr_hi_q ? dst_new[WORD_W-1:HALF_W] : dst_new[HALF_W-1:0];
  assign kept_half = wr_hi_q ? dst_new[HALF_W-1:0] : dst_new[WORD_W-1:HALF_W];

  p_keep_half_r3: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (kept_half == ($past(dst_hi) ? $past(dst_old[HALF_W-1:0])
                                            : $past(dst_old[WORD_W-1:HALF_W]))));

  p_pass_code_r7: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(op) == 2'b11) |->
      (wr_half == ($past(src_hi) ? $past(src_word[WORD_W-1:HALF_W])
                                 : $past(src_word[HALF_W-1:0]))));

  p_amt_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $past(shamt) == '0) |->
      (wr_half == ($past(src_hi) ? $past(src_word[WORD_W-1:HALF_W])
                                 : $past(src_word[HALF_W-1:0]))));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (flag_zero == (wr_half == '0)));

  p_neg_flag_r10: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (flag_neg == wr_half[HALF_W-1]));

  p_cv_clear_r11: assert property (@(posedge clk) disable iff (rst)
    !flag_carry && !flag_ovf0 && !flag_ovf1);

  p_reset_clear_r12: assert property (@(posedge clk)
    $past(rst) |-> (dst_new == '0 && !flag_zero && !flag_neg));
endmodule

// File: tb/hws_shifter_tb.sv
module hws_shifter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_word, dst_old;
  logic        src_hi, dst_hi;
  logic [1:0]  op;
  logic [3:0]  shamt;
  logic [31:0] dst_new;
  logic        flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hws_shifter u_dut (
    .clk(clk), .rst(rst), .src_word(src_word), .dst_old(dst_old),
    .src_hi(src_hi), .dst_hi(dst_hi), .op(op), .shamt(shamt),
    .dst_new(dst_new), .flag_zero(flag_zero), .flag_neg(flag_neg),
    .flag_carry(flag_carry), .flag_ovf0(flag_ovf0), .flag_ovf1(flag_ovf1)
  );

  function automatic logic [15:0] ref_shift(input logic [1:0] o, input logic [15:0] h,
                                            input logic [3:0] a);
    logic signed [15:0] s;
    s = h;
    case (o)
      2'b00:   return h << a;
      2'b01:   return 16'(s >>> a);
      2'b10:   return h >> a;
      default: return h;
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] o, input logic [3:0] a);
    if (a == 0) return "R8";
    case (o)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] s, input logic [31:0] d, input logic sh,
                        input logic dh, input logic [1:0] o, input logic [3:0] a);
    logic [15:0] opnd, res;
    logic [31:0] exp_word;
    @(negedge clk);
    src_word = s; dst_old = d; src_hi = sh; dst_hi = dh; op = o; shamt = a;
    opnd = sh ? s[31:16] : s[15:0];
    res  = ref_shift(o, opnd, a);
    exp_word = dh ? {res, d[15:0]} : {d[31:16], res};
    @(negedge clk);
    check(op_tag(o, a), {16'h0, dh ? dst_new[31:16] : dst_new[15:0]}, {16'h0, res});
    check("R3", {16'h0, dh ? dst_new[15:0] : dst_new[31:16]},
          {16'h0, dh ? d[15:0] : d[31:16]});
    check("R2", dst_new, exp_word);
    check("R9", {31'h0, flag_zero}, {31'h0, res == 16'h0});
    check("R10", {31'h0, flag_neg}, {31'h0, res[15]});
    check("R11", {29'h0, flag_carry, flag_ovf0, flag_ovf1}, 32'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [5];
    corners = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};
    void'($urandom(32'd2718));
    rst = 1'b1; src_word = 32'hFFFF_FFFF; dst_old = 32'hFFFF_FFFF;
    src_hi = 1'b0; dst_hi = 1'b0; op = 2'b00; shamt = 4'd0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", dst_new, 32'h0);
    check("R12", {27'h0, flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1}, 32'h0);
    rst = 1'b0;

    // Directed examples
    run_op(32'h0001_0001, 32'h0000_0000, 1'b0, 1'b0, 2'b00, 4'd4);
    check("R4", dst_new, 32'h0000_0010);
    run_op(32'h8000_0001, 32'h0000_0000, 1'b1, 1'b1, 2'b01, 4'd4);
    check("R5", dst_new, 32'hF800_0000);
    run_op(32'h8000_0001, 32'h0000_0000, 1'b1, 1'b0, 2'b10, 4'd4);
    check("R6", dst_new, 32'h0000_0800);
    run_op(32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 2'b00, 4'd15);
    check("R11", {31'h0, flag_carry}, 32'h0);
    check("R10", {31'h0, flag_neg}, 32'h1);
    run_op(32'h1234_ABCD, 32'h5555_AAAA, 1'b1, 1'b0, 2'b11, 4'd9);
    check("R7", dst_new, 32'h5555_1234);
    run_op(32'h0001_8000, 32'h0000_0000, 1'b0, 1'b1, 2'b10, 4'd15);
    check("R1", dst_new, 32'h0001_0000);
    run_op(32'h0001_8000, 32'h0000_0000, 1'b1, 1'b0, 2'b10, 4'd0);
    check("R1", dst_new, 32'h0000_0001);
    // R9: zero outcome with nonzero kept half, shift 0 of zero operand
    run_op(32'h0001_0000, 32'hFFFF_0001, 1'b0, 1'b0, 2'b00, 4'd0);
    check("R9", {31'h0, flag_zero}, 32'h1);
    run_op(32'h0000_1234, 32'h8000_0000, 1'b0, 1'b0, 2'b10, 4'd15);
    check("R9", {30'h0, flag_zero, flag_neg}, 32'h2);

    // Exhaustive sweep over codes, half pairs and distances on corner operands
    for (int c = 0; c < 5; c++)
      for (int o = 0; o < 4; o++)
        for (int hp = 0; hp < 4; hp++)
          for (int a = 0; a < 16; a++)
            run_op({corners[c], corners[4-c]}, {corners[(c+1)%5], corners[(c+3)%5]},
                   hp[1], hp[0], o[1:0], a[3:0]);

    // Constrained random
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] s, d;
      s = $urandom();
      d = $urandom();
      if (i % 7 == 0) s = s & 32'h8001_8001;
      run_op(s, d, 1'($urandom()), 1'($urandom()), 2'($urandom()), 4'($urandom()));
    end

    // R12: reset mid-stream clears registered outputs
    @(negedge clk);
    src_word = 32'hFFFF_FFFF; dst_old = 32'hFFFF_FFFF; rst = 1'b1;
    @(negedge clk);
    check("R12", dst_new, 32'h0);
    check("R12", {31'h0, flag_neg}, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule